// File: doc/BRIEF.md
# Interrupt Pend and Active Tracker

This block keeps the pending and active state for each source of a small vectored interrupt controller. Each source has one request line. A trigger-type input chooses level or pulse behaviour for the source. The request is registered on the rising clock edge before any decision uses it, so the block has no asynchronous path. The core talks to the block through two one-cycle strobes per source. An activate strobe means the handler has been entered. A return strobe means the handler has exited.

A request that is held for at least one sampled cycle marks the source pending. The pending mark clears when the core activates the source. The two trigger types differ in how the source pends again:

- **Level:** if the request is still high when the handler returns, the source pends again in that same cycle. While the handler runs, the request is ignored.
- **Pulse:** each new rising edge of the request pends the source, even while its handler is active. Edges that arrive while the source is already pending are absorbed.

Arbitration between sources, vector fetch and stacking belong to other blocks.

Top module: `irq_pend_active_tracker`

## Requirements
- R1: While reset is high, and in the first cycle after it, every pend_o and active_o bit is 0.
- R2: A request change on irq_req_i reaches pend_o no sooner than the second rising edge after it is driven. The first edge only registers the request.
- R3: A request that is high for one sampled cycle sets pend_o. pend_o then stays 1 after the request drops, until the source is activated.
- R4: An activate strobe on a source that is pending and not active sets active_o and clears pend_o on the same edge. The exception is a pulse source whose request shows a new rising edge in that cycle: it stays pending.
- R5: An activate strobe on a source that is not pending has no effect. pend_o and active_o do not change.
- R6: A return strobe clears active_o. A return strobe on a source that is not active has no effect.
- R7: For a level source (trigger input 1), if the sampled request is high at return, pend_o is 1 on that same edge and active_o is 0. The source can then be activated again.
- R8: For a level source, if the request is low at return, both pend_o and active_o are 0 after the return.
- R9: For a level source, a request held high while the source is active does not set pend_o.
- R10: For a pulse source (trigger input 0), a new rising edge of the request while the source is active sets pend_o. pend_o and active_o are then both 1.
- R11: For a pulse source, a second rising edge while the source is already pending and not yet active is absorbed. One activation and one return leave the source idle.
- R12: For a pulse source, a request held high sets pend_o only once. Holding it high does not pend the source again after activation.
- R13: The trigger-type input is captured while reset is high. Changing it after reset does not change the trigger type.
- R14: Sources are independent. Strobes and requests on one source never change the state of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock; requests are sampled on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset; also captures irq_mode_i |
| irq_req_i | input | NUM_SRC | Request line per source |
| irq_mode_i | input | NUM_SRC | Trigger type per source: 1 level, 0 pulse |
| activate_i | input | NUM_SRC | One-cycle strobe: the handler for the source was entered |
| exc_return_i | input | NUM_SRC | One-cycle strobe: the handler for the source returned |
| pend_o | output | NUM_SRC | Pending status per source |
| active_o | output | NUM_SRC | Active status per source |

## Verification
Both status bits come straight from registers. A wrong internal state therefore shows at pend_o or active_o on the very edge that produces it. A missed re-pend shows up as pend_o low one cycle after a return while the request is still high. A miscounted pulse shows up as pend_o still high after the single activate and return pair. If the request sampler is wrong, pending appears one edge early or one edge late. The bench runs a cycle-accurate model built from the requirements and compares both vectors after every edge, so any such error is reported in the cycle where it first appears.

// File: rtl/irq_pa_pkg.sv
package irq_pa_pkg;

    typedef enum logic {
        TRIG_PULSE = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;

    typedef struct packed {
        logic pend;
        logic act;
    } slot_state_t;

    // Decide whether this cycle marks the source pending.
    function automatic logic pend_request(
        input trig_mode_e mode,
        input logic       req_s,
        input logic       rise,
        input logic       act,
        input logic       act_go,
        input logic       ret_go
    );
        logic hit;
        if (mode == TRIG_LEVEL) begin
            hit = req_s & ((~act & ~act_go) | ret_go);
        end else begin
            hit = rise;
        end
        return hit;
    endfunction

endpackage

// File: rtl/irq_edge_sampler.sv
module irq_edge_sampler #(
    parameter int W = 4
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] req_i,
    output logic [W-1:0] req_s_o,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] req_q;
    logic [W-1:0] req_qq;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            req_q  <= '0;
            req_qq <= '0;
        end else begin
            req_q  <= req_i;
            req_qq <= req_q;
        end
    end

    assign req_s_o = req_q;
    assign rise_o  = req_q & ~req_qq;

    // R12: an edge indication never lasts two cycles in a row
    assert_rise_single_R12: assert property (@(posedge clk_i) disable iff (rst_i)
        (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/irq_pend_slot.sv
module irq_pend_slot
    import irq_pa_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic mode_i,
    input  logic req_s_i,
    input  logic rise_i,
    input  logic activate_i,
    input  logic return_i,
    output logic pend_o,
    output logic act_o
);
    trig_mode_e  mode_q;
    slot_state_t st_q;
    slot_state_t st_d;
    logic        act_go;
    logic        ret_go;
    logic        set_pend;

    always_comb begin
        act_go   = activate_i & st_q.pend & ~st_q.act;
        ret_go   = return_i & st_q.act;
        set_pend = pend_request(mode_q, req_s_i, rise_i, st_q.act, act_go, ret_go);
        st_d.act  = act_go | (st_q.act & ~ret_go);
        st_d.pend = set_pend | (st_q.pend & ~act_go);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mode_q <= trig_mode_e'(mode_i);
            st_q   <= '0;
        end else begin
            st_q   <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign act_o  = st_q.act;

    assert_activate_clears_pend_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (activate_i && st_q.pend && !st_q.act && !rise_i && !(mode_q == TRIG_LEVEL && return_i))
        |=> (st_q.act && !st_q.pend));

    assert_activate_needs_pend_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(st_q.act) |-> $past(st_q.pend));

    assert_return_clears_act_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (return_i && st_q.act) |=> !st_q.act);

    assert_level_repend_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_q == TRIG_LEVEL && st_q.act && return_i && req_s_i) |=> (st_q.pend && !st_q.act));

    assert_level_quiet_active_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_q == TRIG_LEVEL && st_q.act && !return_i) |=> !st_q.pend);

    assert_pulse_both_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_q == TRIG_PULSE && st_q.act && !return_i && rise_i) |=> (st_q.pend && st_q.act));

    assert_mode_held_R13: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> $stable(mode_q));

endmodule

// File: rtl/irq_pend_active_tracker.sv
module irq_pend_active_tracker #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_SRC-1:0] irq_req_i,
    input  logic [NUM_SRC-1:0] irq_mode_i,
    input  logic [NUM_SRC-1:0] activate_i,
    input  logic [NUM_SRC-1:0] exc_return_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] active_o
);
    logic [NUM_SRC-1:0] req_s;
    logic [NUM_SRC-1:0] rise;

    irq_edge_sampler #(.W(NUM_SRC)) sampler_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .req_i   (irq_req_i),
        .req_s_o (req_s),
        .rise_o  (rise)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
        irq_pend_slot slot_i (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .mode_i     (irq_mode_i[s]),
            .req_s_i    (req_s[s]),
            .rise_i     (rise[s]),
            .activate_i (activate_i[s]),
            .return_i   (exc_return_i[s]),
            .pend_o     (pend_o[s]),
            .act_o      (active_o[s])
        );
    end

    // R1: one cycle after reset nothing is pending or active
    assert_reset_idle_R1: assert property (@(posedge clk_i)
        $past(rst_i) |-> (pend_o == '0 && active_o == '0));

endmodule

// File: tb/irq_pend_active_tracker_tb_top.sv
`timescale 1ns/1ps
module irq_pend_active_tracker_tb_top;
    localparam int N = 2;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] req, mode, actv, ret;
    logic [N-1:0] pend, act;

    always #2 clk = ~clk;

    irq_pend_active_tracker #(.NUM_SRC(N)) dut_i (
        .clk_i(clk), .rst_i(rst), .irq_req_i(req), .irq_mode_i(mode),
        .activate_i(actv), .exc_return_i(ret), .pend_o(pend), .active_o(act)
    );

    typedef struct {
        logic [N-1:0] pend;
        logic [N-1:0] act;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [N-1:0] m_rq, m_rqq, m_pend, m_act, m_mode;

    // Model from the requirements, advanced after each edge
    task automatic model_edge();
        logic [N-1:0] np, na;
        for (int s = 0; s < N; s++) begin
            logic go, back, hit;
            go   = actv[s] && m_pend[s] && !m_act[s];
            back = ret[s] && m_act[s];
            if (m_mode[s]) hit = m_rq[s] && ((!m_act[s] && !go) || back);
            else           hit = m_rq[s] && !m_rqq[s];
            na[s] = go ? 1'b1 : (back ? 1'b0 : m_act[s]);
            np[s] = hit ? 1'b1 : (go ? 1'b0 : m_pend[s]);
        end
        m_pend = np;
        m_act  = na;
        m_rqq  = m_rq;
        m_rq   = req;
    endtask

    task automatic step(input logic [N-1:0] r, input logic [N-1:0] a,
                        input logic [N-1:0] x, input string tag);
        exp_t e;
        req = r; actv = a; ret = x;
        @(posedge clk);
        if (rst) begin
            m_pend = '0; m_act = '0; m_rq = '0; m_rqq = '0; m_mode = mode;
        end else begin
            model_edge();
        end
        e.pend = m_pend; e.act = m_act; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare against the oldest expected item
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (pend !== e.pend || act !== e.act) begin
                errors++;
                $display("FAIL %s: pend=%b act=%b expected pend=%b act=%b",
                         e.tag, pend, act, e.pend, e.act);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; mode = 2'b01; req = '0; actv = '0; ret = '0;
        @(negedge clk);
        step(2'b00, 2'b00, 2'b00, "R1 reset");
        step(2'b11, 2'b11, 2'b00, "R1 reset ignores inputs");
        step(2'b00, 2'b00, 2'b00, "R1 reset");
        rst = 1'b0;
        mode = 2'b10; // R13: swapped after reset, must be ignored
        step(2'b00, 2'b00, 2'b00, "R1 first cycle idle");
        // Level source 0
        step(2'b01, 2'b00, 2'b00, "R2 not pending after first edge");
        step(2'b00, 2'b00, 2'b00, "R3 pend set");
        step(2'b00, 2'b00, 2'b00, "R3 pend held after drop");
        step(2'b00, 2'b10, 2'b00, "R5 activate without pend");
        step(2'b00, 2'b01, 2'b00, "R4 activate");
        step(2'b00, 2'b00, 2'b01, "R8 return with request low");
        step(2'b00, 2'b00, 2'b01, "R6 return while idle");
        step(2'b01, 2'b00, 2'b00, "R3 level held");
        step(2'b01, 2'b00, 2'b00, "R3 level pend");
        step(2'b01, 2'b01, 2'b00, "R4 level activate");
        step(2'b01, 2'b00, 2'b00, "R9 held while active");
        step(2'b01, 2'b00, 2'b00, "R9 R13 still no pend");
        step(2'b01, 2'b00, 2'b01, "R7 repend on return");
        step(2'b01, 2'b01, 2'b00, "R7 reactivate");
        step(2'b00, 2'b00, 2'b00, "R9 active");
        step(2'b00, 2'b00, 2'b01, "R8 idle after return");
        // Pulse source 1
        step(2'b10, 2'b00, 2'b00, "R12 edge");
        step(2'b10, 2'b00, 2'b00, "R12 pend");
        step(2'b10, 2'b00, 2'b00, "R12 held");
        step(2'b10, 2'b10, 2'b00, "R4 pulse activate");
        step(2'b10, 2'b00, 2'b00, "R12 no repend while held");
        step(2'b00, 2'b00, 2'b00, "R12 drop");
        step(2'b10, 2'b00, 2'b00, "R10 new edge");
        step(2'b00, 2'b00, 2'b00, "R10 pend and active");
        step(2'b00, 2'b00, 2'b10, "R6 return keeps pend");
        step(2'b00, 2'b10, 2'b00, "R4 activate again");
        step(2'b00, 2'b00, 2'b10, "R6 return");
        step(2'b10, 2'b00, 2'b00, "R11 first pulse");
        step(2'b00, 2'b00, 2'b00, "R11 pending");
        step(2'b10, 2'b00, 2'b00, "R11 second pulse");
        step(2'b00, 2'b00, 2'b00, "R11 absorbed");
        step(2'b00, 2'b10, 2'b00, "R11 activate");
        step(2'b00, 2'b00, 2'b10, "R11 return");
        step(2'b00, 2'b00, 2'b00, "R11 idle");
        // Both sources
        step(2'b11, 2'b00, 2'b00, "R14 both request");
        step(2'b00, 2'b00, 2'b00, "R14 both pend");
        step(2'b00, 2'b01, 2'b00, "R14 activate only 0");
        step(2'b00, 2'b10, 2'b01, "R14 return 0 activate 1");
        step(2'b00, 2'b00, 2'b10, "R14 return 1");
        step(2'b00, 2'b00, 2'b00, "R14 idle");
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule